// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synchronous single-port memory. A command interface is sampled on every rising clock edge. It carries an address, a three-signal chip select, a load/continue control, a write/read control and active-low per-lane write strobes. Reads and writes may follow each other on consecutive cycles with no idle slot between them.

Read data leaves through an output register two enabled edges after the command is taken. Write data is taken two enabled edges after its command, then held for one cycle in a late-write register before it reaches the array. Reads that hit this held word see the new data.

A 2-bit burst counter walks four beats in either interleaved or linear order. An active-high stall input freezes the whole pipeline. A sleep request deselects the block after two cycles. The output-enable input gates the drivers without a clock.

Top module: `zt_burst_sram`

## Requirements
- R1: While reset is held, and after it is released until the first read completes, `rdata_oe` is 0.
- R2: A read command taken at enabled edge N drives the addressed word on `rdata` with `rdata_oe`=1 after enabled edge N+2. This holds when `drive_en_n`=0 and the block is awake.
- R3: For a write taken at enabled edge N, `wdata` is sampled at enabled edge N+2. Lane l covers bits [9l+8:9l]. Lane l is written only when `lane_wr_n[l]`=0.
- R4: With `burst_cont`=1 the previous read or write continues at the next burst address. `wr_n` and the chip selects are ignored on a continued beat. The strobes of that beat apply.
- R5: With `order_il`=1 the address bits [1:0] of beat b are the start bits XOR b, e.g. start 01 gives 01, 00, 11, 10.
- R6: With `order_il`=0 the address bits [1:0] of beat b are the start bits plus b, modulo 4. Bits above bit 1 stay fixed.
- R7: A command is selected only when `sel_n`=0, `sel_hi`=1 and `sel_lo_n`=0. With `burst_cont`=0, any other combination deselects. Continuing after a deselect stays deselected: no read data is driven and memory is untouched.
- R8: A write with all four strobes at 1 leaves every lane of memory unchanged.
- R9: An edge where `stall`=1 is ignored. Inputs, burst state, pipeline and read output all keep their values.
- R10: `drive_en_n`=1 forces `rdata_oe` to 0 at once. `rdata_oe` is 0 in cycles that carry no read data, including write cycles.
- R11: Inputs sampled two or more edges after `sleep_req` rises are treated as a deselect. `rdata_oe` is 0 while asleep. Sampling resumes at the second edge after `sleep_req` falls.
- R12: A read of an address whose write data is still held in the late-write register returns that data in the written lanes and the array contents in the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | 1 = ignore this clock edge |
| burst_cont | input | 1 | 0 = load new address, 1 = next burst beat |
| sel_n | input | 1 | Active-low chip select |
| sel_hi | input | 1 | Active-high chip select |
| sel_lo_n | input | 1 | Second active-low chip select |
| wr_n | input | 1 | 0 = write, 1 = read (on load) |
| lane_wr_n | input | 4 | Active-low per-lane write strobes |
| addr | input | 8 | Word address |
| order_il | input | 1 | Static burst order: 1 interleaved, 0 linear |
| drive_en_n | input | 1 | Asynchronous active-low output enable |
| sleep_req | input | 1 | Sleep request |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rdata | output | 36 | Read data (0 when not driven) |
| rdata_oe | output | 1 | Read data is driven |

## Verification
The bench keeps a reference memory updated in command order and a four-slot ring of in-flight beats. It goes after these corners:
- Back-to-back write-then-read of the same address. A block without forwarding from the late-write register returns the stale word.
- Continued beats with a flipped `wr_n`. A block that re-decodes direction mid-burst writes where it should read.
- Stall edges scattered inside bursts. A block that lets any one register advance during a stall slips the beat order or the write data alignment by one slot.
- Sleep windows and deselect-then-continue cycles. A block that still decodes a command there drives data or corrupts memory.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              interleave_i,
  output logic [BEAT_W-1:0] lsb_o
);
  always_comb begin
    if (interleave_i) lsb_o = start_i ^ beat_i;
    else              lsb_o = start_i + beat_i;
  end
endmodule

// File: rtl/zt_ctrl.sv
module zt_ctrl
  import zt_sram_pkg::*;
#(
  parameter int AW     = 8,
  parameter int NLANE  = 4,
  parameter int BEAT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             sleep_i,
  input  logic             sel_n_i,
  input  logic             sel_hi_i,
  input  logic             sel_lo_n_i,
  input  logic             cont_i,
  input  logic             wr_n_i,
  input  logic [NLANE-1:0] lane_wr_n_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             interleave_i,
  output logic [AW-1:0]    acc_addr_o,
  output logic             acc_rd_o,
  output logic             acc_wr_o,
  output logic [NLANE-1:0] acc_lane_wr_n_o,
  output logic             asleep_o
);
  logic [1:0]       zz_q;
  logic             s0_sel_q, s0_sel_d, s0_cont_q, s0_cont_d, s0_wr_n_q;
  logic [NLANE-1:0] s0_lane_q;
  logic [AW-1:0]    s0_addr_q;
  op_e              op_q, op_d;
  logic [AW-1:0]    base_q, base_d;
  logic [BEAT_W-1:0] cnt_q, cnt_d, lsb;
  logic [NLANE-1:0] lane_q;

  // sleep request pipe runs on every edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zz_q <= '0;
    else        zz_q <= {zz_q[0], sleep_i};
  end
  assign asleep_o = zz_q[1];

  always_comb begin
    if (zz_q[1]) begin
      s0_sel_d  = 1'b0;
      s0_cont_d = 1'b0;
    end else begin
      s0_sel_d  = !sel_n_i && sel_hi_i && !sel_lo_n_i;
      s0_cont_d = cont_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_sel_q  <= 1'b0;
      s0_cont_q <= 1'b0;
      s0_wr_n_q <= 1'b1;
      s0_lane_q <= '1;
      s0_addr_q <= '0;
    end else if (en_i) begin
      s0_sel_q  <= s0_sel_d;
      s0_cont_q <= s0_cont_d;
      s0_wr_n_q <= wr_n_i;
      s0_lane_q <= lane_wr_n_i;
      s0_addr_q <= addr_i;
    end
  end

  always_comb begin
    op_d   = op_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (!s0_cont_q) begin
      base_d = s0_addr_q;
      cnt_d  = '0;
      if (!s0_sel_q)     op_d = OP_IDLE;
      else if (s0_wr_n_q) op_d = OP_READ;
      else               op_d = OP_WRITE;
    end else if (op_q != OP_IDLE) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      lane_q <= '1;
    end else if (en_i) begin
      op_q   <= op_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      lane_q <= s0_lane_q;
    end
  end

  zt_burst_seq #(.BEAT_W(BEAT_W)) u_seq (
    .start_i      (base_q[BEAT_W-1:0]),
    .beat_i       (cnt_q),
    .interleave_i (interleave_i),
    .lsb_o        (lsb)
  );

  assign acc_addr_o      = {base_q[AW-1:BEAT_W], lsb};
  assign acc_rd_o        = (op_q == OP_READ);
  assign acc_wr_o        = (op_q == OP_WRITE);
  assign acc_lane_wr_n_o = lane_q;
endmodule

// File: rtl/zt_datapath.sv
module zt_datapath #(
  parameter int AW    = 8,
  parameter int NLANE = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [AW-1:0]       acc_addr_i,
  input  logic                acc_rd_i,
  input  logic                acc_wr_i,
  input  logic [NLANE-1:0]    acc_lane_wr_n_i,
  input  logic [NLANE*LW-1:0] wdata_i,
  output logic [NLANE*LW-1:0] rd_word_o,
  output logic                rd_vld_o
);
  localparam int W     = NLANE * LW;
  localparam int DEPTH = 1 << AW;

  logic             pend_v_q;
  logic [AW-1:0]    pend_addr_q;
  logic [NLANE-1:0] pend_lane_q;
  logic [W-1:0]     pend_data_q;
  logic             out_v_q;
  logic [W-1:0]     out_word_q, out_word_n, merge_word;
  logic             hit;

  assign hit = pend_v_q && (pend_addr_q == acc_addr_i);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LW-1:0] mem_q [DEPTH];
    always_ff @(posedge clk) begin
      if (en_i && pend_v_q && !pend_lane_q[g])
        mem_q[pend_addr_q] <= pend_data_q[g*LW +: LW];
    end
    assign merge_word[g*LW +: LW] = (hit && !pend_lane_q[g]) ?
                                    pend_data_q[g*LW +: LW] : mem_q[acc_addr_i];
  end

  always_comb out_word_n = acc_rd_i ? merge_word : out_word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q    <= 1'b0;
      pend_addr_q <= '0;
      pend_lane_q <= '1;
      pend_data_q <= '0;
      out_v_q     <= 1'b0;
      out_word_q  <= '0;
    end else if (en_i) begin
      pend_v_q    <= acc_wr_i;
      pend_addr_q <= acc_addr_i;
      pend_lane_q <= acc_lane_wr_n_i;
      pend_data_q <= wdata_i;
      out_v_q     <= acc_rd_i;
      out_word_q  <= out_word_n;
    end
  end

  assign rd_word_o = out_word_q;
  assign rd_vld_o  = out_v_q;
endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stall,
  input  logic                    burst_cont,
  input  logic                    sel_n,
  input  logic                    sel_hi,
  input  logic                    sel_lo_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    order_il,
  input  logic                    drive_en_n,
  input  logic                    sleep_req,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int W = LANES * LANE_W;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n, en, asleep;
  logic [ADDR_W-1:0] acc_addr;
  logic             acc_rd, acc_wr;
  logic [LANES-1:0] acc_lane;
  logic [W-1:0]     rd_word;
  logic             rd_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];
  assign en         = !stall;

  zt_ctrl #(.AW(ADDR_W), .NLANE(LANES), .BEAT_W(2)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_core_n),
    .en_i            (en),
    .sleep_i         (sleep_req),
    .sel_n_i         (sel_n),
    .sel_hi_i        (sel_hi),
    .sel_lo_n_i      (sel_lo_n),
    .cont_i          (burst_cont),
    .wr_n_i          (wr_n),
    .lane_wr_n_i     (lane_wr_n),
    .addr_i          (addr),
    .interleave_i    (order_il),
    .acc_addr_o      (acc_addr),
    .acc_rd_o        (acc_rd),
    .acc_wr_o        (acc_wr),
    .acc_lane_wr_n_o (acc_lane),
    .asleep_o        (asleep)
  );

  zt_datapath #(.AW(ADDR_W), .NLANE(LANES), .LW(LANE_W)) u_dp (
    .clk             (clk),
    .rst_n           (rst_core_n),
    .en_i            (en),
    .acc_addr_i      (acc_addr),
    .acc_rd_i        (acc_rd),
    .acc_wr_i        (acc_wr),
    .acc_lane_wr_n_i (acc_lane),
    .wdata_i         (wdata),
    .rd_word_o       (rd_word),
    .rd_vld_o        (rd_vld)
  );

  assign rdata_oe = rd_vld && !drive_en_n && !asleep;
  assign rdata    = rdata_oe ? rd_word : '0;
endmodule

// File: rtl/zt_burst_sram_chk.sv
module zt_burst_sram_chk #(
  parameter int W = 36
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stall,
  input logic         drive_en_n,
  input logic         sleep_req,
  input logic         rdata_oe,
  input logic         rd_vld,
  input logic [W-1:0] rd_word
);
  // R1
  reset_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rdata_oe);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(rd_vld) && $stable(rd_word)));

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en_n |-> !rdata_oe);

  // R11
  sleep_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep_req, 2) |-> !rdata_oe);
endmodule

bind zt_burst_sram zt_burst_sram_chk #(.W(W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .drive_en_n (drive_en_n),
  .sleep_req  (sleep_req),
  .rdata_oe   (rdata_oe),
  .rd_vld     (rd_vld),
  .rd_word    (rd_word)
);

// File: tb/test_zt_burst_sram.sv
`timescale 1ns/1ps
module test_zt_burst_sram;
  localparam int AW = 8;
  localparam int W  = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0, burst_cont = 1'b0, sel_n = 1'b1, sel_hi = 1'b0, sel_lo_n = 1'b1;
  logic wr_n = 1'b1, order_il = 1'b0, drive_en_n = 1'b0, sleep_req = 1'b0;
  logic [3:0]    lane_wr_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          rdata_oe;

  always #4 clk = ~clk;

  zt_burst_sram i_zt_burst_sram (
    .clk(clk), .rst_n(rst_n), .stall(stall), .burst_cont(burst_cont),
    .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .addr(addr), .order_il(order_il),
    .drive_en_n(drive_en_n), .sleep_req(sleep_req), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int nchk = 0, nfail = 0, en_cnt = 0;
  logic [W-1:0]  ref_mem [256];
  logic [1:0]    s_op [4];
  logic [W-1:0]  s_val [4];
  logic [1:0]    m_op = 2'd0, m_beat = 2'd0;
  logic [AW-1:0] m_base = '0;
  logic          last_rd = 1'b0, zh1 = 1'b0, zh2 = 1'b0;
  logic [W-1:0]  last_exp = '0;

  task automatic chk(input bit ok, input string t, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // one clock: check the previous edge's outputs, then drive the next edge
  task automatic step(input string t, input logic st, input logic cont, input logic [2:0] cs,
                      input logic wrn, input logic [3:0] bw, input logic [AW-1:0] a,
                      input logic oen, input logic zz, input logic il);
    logic exp_oe;
    logic [1:0] lsb;
    logic [AW-1:0] eff;
    int pk, ck;
    @(negedge clk);
    exp_oe = last_rd && !drive_en_n && !zh2;
    chk(rdata_oe === exp_oe, t, W'(rdata_oe), W'(exp_oe));
    if (exp_oe) chk(rdata === last_exp, t, rdata, last_exp);
    stall = st; burst_cont = cont; sel_n = cs[2]; sel_hi = !cs[1]; sel_lo_n = cs[0];
    wr_n = wrn; lane_wr_n = bw; addr = a; drive_en_n = oen; sleep_req = zz; order_il = il;
    wdata = W'({$urandom(), $urandom()});
    if (!st) begin
      if (zh2 || (!cont && cs != 3'd0)) m_op = 2'd0;
      else if (!cont) begin m_op = wrn ? 2'd1 : 2'd2; m_base = a; m_beat = 2'd0; end
      else if (m_op != 2'd0) m_beat = m_beat + 2'd1;
      lsb = il ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
      eff = {m_base[AW-1:2], lsb};
      pk = (en_cnt + 2) % 4;
      ck = en_cnt % 4;
      if (s_op[pk] == 2'd2) wdata = s_val[pk];
      last_rd  = (s_op[pk] == 2'd1);
      last_exp = s_val[pk];
      s_op[ck] = m_op;
      if (m_op == 2'd2) begin
        s_val[ck] = W'({$urandom(), $urandom()});
        for (int l = 0; l < 4; l++)
          if (!bw[l]) ref_mem[eff][l*9 +: 9] = s_val[ck][l*9 +: 9];
      end else if (m_op == 2'd1) begin
        s_val[ck] = ref_mem[eff];
      end
      en_cnt++;
    end
    zh2 = zh1; zh1 = zz;
  endtask

  task automatic idle(input string t, input int n, input logic il);
    for (int i = 0; i < n; i++) step(t, 1'b0, 1'b0, 3'd4, 1'b1, 4'hF, '0, 1'b0, 1'b0, il);
  endtask

  task automatic rand_ops(input string t, input int n, input int p_st, input int p_ds,
                          input int p_oe, input int p_ab, input int p_bu,
                          input int zlo, input int zhi, input logic il);
    int rem;
    rem = 0;
    for (int i = 0; i < n; i++) begin
      logic st, oen, wrn, cont, zz;
      logic [2:0] cs;
      logic [3:0] bw;
      st  = ($urandom % 100) < p_st;
      oen = ($urandom % 100) < p_oe;
      wrn = 1'($urandom);
      bw  = (($urandom % 100) < p_ab) ? 4'hF : 4'($urandom);
      zz  = (i >= zlo) && (i < zhi);
      cs  = 3'd0;
      cont = 1'b0;
      if (rem > 0) begin
        cont = 1'b1;
        cs = 3'($urandom);
        if (!st) rem--;
      end else if (($urandom % 100) < p_ds) begin
        cs = 3'(1 + $urandom % 7);
        if (!st) rem = $urandom % 3;
      end else if (!st) begin
        rem = (($urandom % 100) < p_bu) ? 3 : 0;
      end
      step(t, st, cont, cs, wrn, bw, AW'($urandom), oen, zz, il);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin s_op[i] = 2'd0; s_val[i] = '0; end
    // R1: outputs undriven in and just after reset
    repeat (3) begin @(negedge clk); chk(rdata_oe === 1'b0, "R1", W'(rdata_oe), '0); end
    rst_n = 1'b1;
    idle("R1", 6, 1'b0);
    // R6: fill memory with linear bursts, then read it back the same way
    for (int b = 0; b < 64; b++)
      for (int j = 0; j < 4; j++)
        step("R6", 1'b0, j != 0, 3'd0, 1'b0, 4'h0, AW'(b*4 + 1), 1'b0, 1'b0, 1'b0);
    for (int b = 0; b < 64; b++)
      for (int j = 0; j < 4; j++)
        step("R6", 1'b0, j != 0, 3'd0, 1'b1, 4'h0, AW'(b*4 + (b % 4)), 1'b0, 1'b0, 1'b0);
    idle("R6", 4, 1'b0);
    // R5: interleaved bursts from every start offset
    for (int b = 0; b < 32; b++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      for (int j = 0; j < 4; j++) step("R5", 1'b0, j != 0, 3'd0, 1'b0, 4'($urandom), a, 1'b0, 1'b0, 1'b1);
      for (int j = 0; j < 4; j++) step("R5", 1'b0, j != 0, 3'd0, 1'b1, 4'h0, a, 1'b0, 1'b0, 1'b1);
    end
    idle("R5", 4, 1'b1);
    rand_ops("R2", 200, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    rand_ops("R3", 300, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    rand_ops("R8", 300, 0, 0, 0, 50, 30, 0, 0, 1'b0);
    rand_ops("R7", 300, 0, 40, 0, 10, 30, 0, 0, 1'b0);
    // R4: continued beats flip wr_n, which must be ignored
    for (int b = 0; b < 16; b++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      step("R4", 1'b0, 1'b0, 3'd0, 1'b0, 4'h0, a, 1'b0, 1'b0, 1'b0);
      for (int j = 0; j < 3; j++) step("R4", 1'b0, 1'b1, 3'($urandom), 1'b1, 4'($urandom), AW'($urandom), 1'b0, 1'b0, 1'b0);
      step("R4", 1'b0, 1'b0, 3'd0, 1'b1, 4'h0, a, 1'b0, 1'b0, 1'b0);
      for (int j = 0; j < 3; j++) step("R4", 1'b0, 1'b1, 3'd0, 1'b0, 4'h0, AW'($urandom), 1'b0, 1'b0, 1'b0);
    end
    rand_ops("R9", 600, 35, 15, 0, 10, 40, 0, 0, 1'b0);
    rand_ops("R10", 300, 10, 10, 40, 10, 30, 0, 0, 1'b0);
    for (int r = 0; r < 4; r++) rand_ops("R11", 40, 10, 10, 0, 10, 30, 12, 22, 1'b0);
    // R12: write then read of the same word on consecutive edges
    for (int b = 0; b < 40; b++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      step("R12", 1'b0, 1'b0, 3'd0, 1'b0, 4'($urandom), a, 1'b0, 1'b0, 1'b0);
      step("R12", 1'b0, 1'b0, 3'd0, 1'b1, 4'h0, a, 1'b0, 1'b0, 1'b0);
      step("R12", 1'b0, 1'b0, 3'd0, 1'b0, 4'($urandom), a, 1'b0, 1'b0, 1'b0);
      step("R12", 1'b0, 1'b0, 3'd0, 1'b1, 4'h0, a, 1'b0, 1'b0, 1'b0);
    end
    idle("R12", 5, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule